// File: doc/BRIEF.md
# Reset and Power Control Sequencer

This block sits behind a write-only power control byte. A single write can request power-off, a full or normal reboot, a memory-only reset, or advance notice of sleep. Each reboot or memory command pulls a particular set of three active-low reset lines: the main SoC reset, the secondary reset and the memory reset. The block holds those lines low for a fixed hold interval and releases them all in the same cycle. It then waits a longer settle interval and raises a one-cycle pulse that tells the rest of the chip to reinitialise its registers. The main SoC reset line stands for a command sent to a power-management device; here it is only a level.

The sleep bit never stays in the register. It gives a single notification pulse and clears itself. Only the low four command bits have a lasting effect. The normal reboot command also clears the legacy-compatibility registers, and it pulls the memory reset only when the legacy emulation flag is high at the moment of the write. While a sequence is running, `busy` is high and every write is dropped.

Both intervals are counted in clock cycles and set by parameters. The defaults give 5 ms and 100 ms at 200 MHz. The write port is a plain strobe with no back-pressure: a write that lands while `busy` is high is discarded, not stalled.

Top module: `pwr_rst_seq`

## Requirements
- R1: After `rst_n` is low, all three reset outputs are high, and `pwr_off_req`, `sleep_pulse`, `compat_clr`, `reinit_pulse` and `busy` are low.
- R2: An accepted write with bit 1 (full reboot) set pulls `soc_rst_n`, `sec_rst_n` and `mem_rst_n` low in the cycle after the write.
- R3: An accepted write with bit 2 (normal reboot) set pulls `sec_rst_n` low. It pulls `mem_rst_n` low only if `legacy_mode` was high at the write, leaves `soc_rst_n` high, and raises `compat_clr` for exactly one cycle after the write.
- R4: An accepted write with bit 3 (memory reset) set pulls only `mem_rst_n` low.
- R5: When several of bits 1 to 3 are set in one write, the asserted lines are the union of the sets each bit selects.
- R6: An accepted write with bit 0 set raises `pwr_off_req` from the next cycle. It stays high until `rst_n`. Bit 0 alone touches no reset line and does not raise `busy`.
- R7: An accepted write with bit 4 set raises `sleep_pulse` for exactly one cycle after the write. Bit 4 alone does not raise `busy`.
- R8: The selected reset lines stay low for exactly HOLD_CYC cycles and all go high in the same cycle.
- R9: `reinit_pulse` is high for exactly one cycle, WAIT_CYC cycles after the first cycle in which the reset lines are released.
- R10: `busy` is high from the cycle after an accepted reset write up to and including the `reinit_pulse` cycle, and low in the next cycle.
- R11: A write made while `busy` is high has no effect on any output, including the cycle in which `reinit_pulse` is high.
- R12: A write with none of bits 0 to 4 set (for example 0xE0) has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte; bit0 power-off, bit1 full reboot, bit2 normal reboot, bit3 memory reset, bit4 sleep notice |
| legacy_mode | input | 1 | Legacy emulation active; adds the memory reset to a normal reboot |
| soc_rst_n | output | 1 | Main SoC reset, active low (level standing for the power-management command) |
| sec_rst_n | output | 1 | Secondary reset, active low |
| mem_rst_n | output | 1 | Memory reset, active low |
| pwr_off_req | output | 1 | Sticky power-off request |
| sleep_pulse | output | 1 | One-cycle sleep notification |
| compat_clr | output | 1 | One-cycle clear of the legacy-compatibility registers |
| reinit_pulse | output | 1 | One-cycle request to reinitialise registers |
| busy | output | 1 | Sequence in progress; writes are ignored |

## Verification
Two functions can land in the same cycle. One is the end of a sequence, where `reinit_pulse` is high. The other is the acceptance of a new write. The bench provokes this by holding `wr_en` high with a memory-reset command through a whole sequence. The write made in the reinit cycle must be dropped, and the one in the next cycle must start a fresh hold. A second case puts the sleep bit and a normal reboot in one byte, so `sleep_pulse`, `compat_clr` and the start of the hold all appear in the same cycle. The behavioural model checks every output in every cycle.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;
  localparam int CMD_W      = 8;
  localparam int BIT_PWROFF = 0;
  localparam int BIT_FULL   = 1;
  localparam int BIT_NORM   = 2;
  localparam int BIT_MEM    = 3;
  localparam int BIT_SLEEP  = 4;

  localparam int NRST    = 3;
  localparam int RST_SOC = 0;
  localparam int RST_SEC = 1;
  localparam int RST_MEM = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_HOLD,
    SEQ_WAIT,
    SEQ_REINIT
  } seq_state_e;
endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode
  import pwr_rst_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  input  logic             legacy_mode,
  output logic [NRST-1:0]  rst_sel,
  output logic             any_rst,
  output logic             pwroff,
  output logic             sleep,
  output logic             compat
);
  always_comb begin
    rst_sel = '0;
    if (cmd[BIT_FULL]) begin
      rst_sel = '1;
    end
    if (cmd[BIT_NORM]) begin
      rst_sel[RST_SEC] = 1'b1;
      if (legacy_mode) rst_sel[RST_MEM] = 1'b1;
    end
    if (cmd[BIT_MEM]) begin
      rst_sel[RST_MEM] = 1'b1;
    end
  end

  assign any_rst = |rst_sel;
  assign pwroff  = cmd[BIT_PWROFF];
  assign sleep   = cmd[BIT_SLEEP];
  assign compat  = cmd[BIT_NORM];
endmodule

// File: rtl/pwr_rst_timer.sv
module pwr_rst_timer
  import pwr_rst_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 1_000_000,
  parameter int unsigned WAIT_CYC = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic hold_active,
  output logic reinit,
  output logic busy
);
  localparam int unsigned MAX_CYC = (HOLD_CYC > WAIT_CYC) ? HOLD_CYC : WAIT_CYC;
  localparam int          CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_CYC - 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_HOLD;
            cnt_q   <= '0;
          end
        end
        SEQ_HOLD: begin
          if (cnt_q == HOLD_LAST) begin
            state_q <= SEQ_WAIT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_WAIT: begin
          if (cnt_q == WAIT_LAST) begin
            state_q <= SEQ_REINIT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= SEQ_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign hold_active = (state_q == SEQ_HOLD);
  assign reinit      = (state_q == SEQ_REINIT);
  assign busy        = (state_q != SEQ_IDLE);
endmodule

// File: rtl/pwr_rst_drive.sv
module pwr_rst_drive
  import pwr_rst_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NRST-1:0] rst_sel,
  input  logic            hold_active,
  output logic [NRST-1:0] rst_lines_n
);
  for (genvar i = 0; i < NRST; i++) begin : g_line
    logic sel_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sel_q <= 1'b0;
      else if (load) sel_q <= rst_sel[i];
    end
    assign rst_lines_n[i] = ~(sel_q & hold_active);
  end
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
  import pwr_rst_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 1_000_000,
  parameter int unsigned WAIT_CYC = 20_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       legacy_mode,
  output logic       soc_rst_n,
  output logic       sec_rst_n,
  output logic       mem_rst_n,
  output logic       pwr_off_req,
  output logic       sleep_pulse,
  output logic       compat_clr,
  output logic       reinit_pulse,
  output logic       busy
);
  logic [NRST-1:0] rst_sel;
  logic [NRST-1:0] lines_n;
  logic            any_rst, dec_pwroff, dec_sleep, dec_compat;
  logic            accept, start, hold_active;
  logic            pwroff_q, sleep_q, compat_q;

  pwr_cmd_decode u_dec (
    .cmd         (wr_data),
    .legacy_mode (legacy_mode),
    .rst_sel     (rst_sel),
    .any_rst     (any_rst),
    .pwroff      (dec_pwroff),
    .sleep       (dec_sleep),
    .compat      (dec_compat)
  );

  assign accept = wr_en & ~busy;
  assign start  = accept & any_rst;

  pwr_rst_timer #(
    .HOLD_CYC (HOLD_CYC),
    .WAIT_CYC (WAIT_CYC)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .hold_active (hold_active),
    .reinit      (reinit_pulse),
    .busy        (busy)
  );

  pwr_rst_drive u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (start),
    .rst_sel     (rst_sel),
    .hold_active (hold_active),
    .rst_lines_n (lines_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwroff_q <= 1'b0;
      sleep_q  <= 1'b0;
      compat_q <= 1'b0;
    end else begin
      pwroff_q <= pwroff_q | (accept & dec_pwroff);
      sleep_q  <= accept & dec_sleep;
      compat_q <= accept & dec_compat;
    end
  end

  assign soc_rst_n   = lines_n[RST_SOC];
  assign sec_rst_n   = lines_n[RST_SEC];
  assign mem_rst_n   = lines_n[RST_MEM];
  assign pwr_off_req = pwroff_q;
  assign sleep_pulse = sleep_q;
  assign compat_clr  = compat_q;
endmodule

// File: rtl/pwr_rst_seq_chk.sv
module pwr_rst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       soc_rst_n,
  input logic       sec_rst_n,
  input logic       mem_rst_n,
  input logic       pwr_off_req,
  input logic       sleep_pulse,
  input logic       compat_clr,
  input logic       reinit_pulse,
  input logic       busy
);
  // R2
  full_all_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && wr_data[1]) |=> (!soc_rst_n && !sec_rst_n && !mem_rst_n));

  // R4
  mem_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && wr_data[3:1] == 3'b100) |=> (!mem_rst_n && soc_rst_n && sec_rst_n));

  // R6
  pwroff_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_req |=> pwr_off_req);

  // R7
  sleep_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_pulse |=> !sleep_pulse);

  // R8
  release_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(soc_rst_n) || $rose(sec_rst_n) || $rose(mem_rst_n)) |-> (soc_rst_n && sec_rst_n && mem_rst_n));

  // R9
  reinit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_pulse |=> (!reinit_pulse && !busy));

  // R10
  low_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soc_rst_n || !sec_rst_n || !mem_rst_n) |-> busy);

  // R11
  busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> (!sleep_pulse && !compat_clr));
endmodule

bind pwr_rst_seq pwr_rst_seq_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .soc_rst_n    (soc_rst_n),
  .sec_rst_n    (sec_rst_n),
  .mem_rst_n    (mem_rst_n),
  .pwr_off_req  (pwr_off_req),
  .sleep_pulse  (sleep_pulse),
  .compat_clr   (compat_clr),
  .reinit_pulse (reinit_pulse),
  .busy         (busy)
);

// File: tb/pwr_rst_seq_tb_top.sv
`timescale 1ns/100ps
module pwr_rst_seq_tb_top;
  localparam int H = 4;
  localparam int W = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       legacy = 1'b0;
  logic soc_rst_n, sec_rst_n, mem_rst_n, pwr_off_req, sleep_pulse, compat_clr, reinit_pulse, busy;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pwr_rst_seq #(.HOLD_CYC(H), .WAIT_CYC(W)) dut_i (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
    .legacy_mode (legacy), .soc_rst_n (soc_rst_n), .sec_rst_n (sec_rst_n),
    .mem_rst_n (mem_rst_n), .pwr_off_req (pwr_off_req), .sleep_pulse (sleep_pulse),
    .compat_clr (compat_clr), .reinit_pulse (reinit_pulse), .busy (busy)
  );

  // Behavioural reference: age counts cycles since a sequence was accepted, -1 when idle.
  int   age = -1;
  bit [2:0] m_sel = 3'b000;   // {mem, sec, soc}
  bit   m_pwroff = 1'b0, m_sleep = 1'b0, m_compat = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age = -1; m_sel = 3'b000; m_pwroff = 0; m_sleep = 0; m_compat = 0;
    end else begin
      bit was_busy;
      was_busy = (age >= 0);
      m_sleep = 0; m_compat = 0;
      if (age >= 0) begin
        age++;
        if (age > H + W) age = -1;
      end
      if (wr_en && !was_busy) begin
        if (wr_data[0]) m_pwroff = 1;
        if (wr_data[4]) m_sleep = 1;
        if (wr_data[2]) m_compat = 1;
        if (wr_data[1] || wr_data[2] || wr_data[3]) begin
          age = 0;
          m_sel[0] = wr_data[1];
          m_sel[1] = wr_data[1] | wr_data[2];
          m_sel[2] = wr_data[1] | wr_data[3] | (wr_data[2] & legacy);
        end
      end
    end
  end

  task automatic cmp(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  bit comparing = 1'b0;
  always @(negedge clk) begin
    if (comparing) begin
      bit holding;
      holding = (age >= 0) && (age < H);
      cmp("R2 R5 R8 soc_rst_n", soc_rst_n, !(holding && m_sel[0]));
      cmp("R3 R8 sec_rst_n",    sec_rst_n, !(holding && m_sel[1]));
      cmp("R3 R4 mem_rst_n",    mem_rst_n, !(holding && m_sel[2]));
      cmp("R6 pwr_off_req",     pwr_off_req, m_pwroff);
      cmp("R7 sleep_pulse",     sleep_pulse, m_sleep);
      cmp("R3 compat_clr",      compat_clr, m_compat);
      cmp("R9 reinit_pulse",    reinit_pulse, age == H + W);
      cmp("R10 R11 R12 busy",   busy, age >= 0);
    end
  end

  task automatic drive(input logic en, input logic [7:0] d, input logic lg);
    @(posedge clk); #1;
    wr_en = en; wr_data = d; legacy = lg;
  endtask
  task automatic pulse(input logic [7:0] d, input logic lg);
    drive(1'b1, d, lg);
    drive(1'b0, 8'h00, lg);
  endtask
  task automatic gap(input int n);
    repeat (n) drive(1'b0, 8'h00, legacy);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    cmp("R1 soc_rst_n", soc_rst_n, 1'b1);
    cmp("R1 sec_rst_n", sec_rst_n, 1'b1);
    cmp("R1 mem_rst_n", mem_rst_n, 1'b1);
    cmp("R1 busy", busy, 1'b0);
    cmp("R1 reinit_pulse", reinit_pulse, 1'b0);
    cmp("R1 pwr_off_req", pwr_off_req, 1'b0);
    comparing = 1'b1;
    @(posedge clk); #1; rst_n = 1'b1;
    gap(2);
    pulse(8'h02, 1'b0); gap(14);          // R2 full reboot
    pulse(8'h04, 1'b0); gap(14);          // R3 normal, no legacy
    pulse(8'h04, 1'b1); gap(14);          // R3 normal, legacy
    pulse(8'h08, 1'b0); gap(14);          // R4 memory only
    pulse(8'h0C, 1'b0); gap(14);          // R5 union
    pulse(8'h10, 1'b0); gap(3);           // R7 sleep alone
    pulse(8'h14, 1'b1); gap(14);          // R7 with normal reboot, same cycle
    pulse(8'hE0, 1'b0); gap(3);           // R12 no-op bits
    repeat (30) drive(1'b1, 8'h08, 1'b0); // R11 writes through busy and reinit cycle
    gap(14);
    pulse(8'h02, 1'b0); gap(2);
    pulse(8'h11, 1'b0); gap(14);          // R11 ignored sleep+power-off
    pulse(8'h01, 1'b0); gap(5);           // R6 sticky power-off
    @(posedge clk); #1; rst_n = 1'b0;
    gap(2);
    @(posedge clk); #1; rst_n = 1'b1;
    gap(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule